// File: doc/BRIEF.md
# Low-Power Mode Clock Controller

This block sets the operating mode of a small processor subsystem and turns that mode into six registered enables. The enables are for the CPU core, the main clock, the sub-main clock, the auxiliary clock, the oscillator bias generator and the crystal oscillator. Software picks one of six modes with a 3-bit code: one active mode and five sleep levels, numbered LPM0 to LPM4. At each deeper level more of the clock tree is switched off, until LPM4 leaves everything off.

When an interrupt request arrives outside a handler, the block forces active mode and stores the interrupted mode in a one-entry shadow register. A return-from-interrupt strobe then reloads that stored mode, so the core goes back to sleep without any software action. The block only models the gating as enable signals. It does not include the oscillators, the frequency settings or the vector fetch.

Top module: `lpm_clk_ctrl`

## Requirements
- R1: While reset is active, and after it is released, `mode_o` is 0 and all six enables are 1.
- R2: Mode codes are 0 = active, 1 = LPM0, 2 = LPM1, 3 = LPM2, 4 = LPM3 and 5 = LPM4. A write (`mode_we_i` high) loads `mode_i` into the mode register at the next clock edge. The enables change at that same edge. In active mode all six enables are 1.
- R3: In LPM0, `cpu_en_o` and `mclk_en_o` are 0. `smclk_en_o`, `aclk_en_o`, `bias_en_o` and `xtal_en_o` are 1.
- R4: LPM1 has the same pattern as LPM0, except that `bias_en_o` follows `osc_in_use_i`. It is 0 when the internal oscillator is not in use in active mode.
- R5: In LPM2, `cpu_en_o`, `mclk_en_o` and `smclk_en_o` are 0. `aclk_en_o`, `bias_en_o` and `xtal_en_o` are 1.
- R6: In LPM3, `cpu_en_o`, `mclk_en_o`, `smclk_en_o` and `bias_en_o` are 0. `aclk_en_o` and `xtal_en_o` are 1.
- R7: In LPM4, all six enables are 0.
- R8: Codes 6 and 7 are stored and shown on `mode_o` as written. The enables for these codes are the active-mode pattern.
- R9: Consider any bit of `irq_i` that is high while no handler is running. At the next edge, `mode_o` becomes 0, all enables become 1, the previous mode code is saved and a handler is marked as running. A mode write in the same cycle is dropped.
- R10: A `reti_i` pulse while a handler is running reloads the saved mode at the next edge and ends the handler.
- R11: While a handler is running, further interrupts do not change the mode or the saved mode. A `reti_i` pulse while no handler is running has no effect.
- R12: A mode write during a handler changes the current mode. The following return still restores the mode saved at wake-up.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_we_i | input | 1 | Mode write strobe |
| mode_i | input | 3 | Mode code to write |
| irq_i | input | NUM_IRQ | Interrupt request lines |
| reti_i | input | 1 | Return-from-interrupt strobe |
| osc_in_use_i | input | 1 | Internal oscillator is used in active mode |
| mode_o | output | 3 | Current mode register |
| cpu_en_o | output | 1 | CPU enable |
| mclk_en_o | output | 1 | Main clock enable |
| smclk_en_o | output | 1 | Sub-main clock enable |
| aclk_en_o | output | 1 | Auxiliary clock enable |
| bias_en_o | output | 1 | Oscillator bias generator enable |
| xtal_en_o | output | 1 | Crystal oscillator enable |

## Verification
The properties assume that `reti_i` is a single-cycle pulse sent only as a handler ends. They also assume that any bit of `irq_i` counts as a wake request, with no masking. The stimulus drives each strobe for exactly one cycle. It sends returns both inside and outside a handler, and it stacks interrupts and writes on top of a running handler. In this way the priority of wake-up over return and over write is seen from the ports. Bias-enable behaviour in LPM1 is checked with `osc_in_use_i` at both levels.

// File: rtl/lpm_pkg.sv
package lpm_pkg;
  localparam int unsigned MODE_W = 3;

  typedef enum logic [MODE_W-1:0] {
    MODE_AM   = 3'd0,
    MODE_LPM0 = 3'd1,
    MODE_LPM1 = 3'd2,
    MODE_LPM2 = 3'd3,
    MODE_LPM3 = 3'd4,
    MODE_LPM4 = 3'd5
  } mode_e;

  typedef struct packed {
    logic cpu;
    logic mclk;
    logic smclk;
    logic aclk;
    logic bias;
    logic xtal;
  } gate_t;

  localparam gate_t GATE_ALL_ON = '1;
endpackage

// File: rtl/lpm_mode_seq.sv
module lpm_mode_seq
  import lpm_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              mode_we_i,
  input  logic [MODE_W-1:0] mode_i,
  input  logic              wake_req_i,
  input  logic              reti_i,
  output logic [MODE_W-1:0] mode_d_o,
  output logic [MODE_W-1:0] mode_q_o,
  output logic [MODE_W-1:0] shadow_q_o,
  output logic              in_isr_o
);
  logic [MODE_W-1:0] mode_q, shadow_q, shadow_d;
  logic              in_isr_q, in_isr_d;
  logic              wake, ret;

  assign wake = wake_req_i && !in_isr_q;
  assign ret  = reti_i && in_isr_q;

  // priority: wake > return > software write
  always_comb begin
    mode_d_o = mode_q;
    shadow_d = shadow_q;
    in_isr_d = in_isr_q;
    if (wake) begin
      shadow_d = mode_q;
      mode_d_o = MODE_AM;
      in_isr_d = 1'b1;
    end else if (ret) begin
      mode_d_o = shadow_q;
      in_isr_d = 1'b0;
    end else if (mode_we_i) begin
      mode_d_o = mode_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q   <= MODE_AM;
      shadow_q <= MODE_AM;
      in_isr_q <= 1'b0;
    end else begin
      mode_q   <= mode_d_o;
      shadow_q <= shadow_d;
      in_isr_q <= in_isr_d;
    end
  end

  assign mode_q_o   = mode_q;
  assign shadow_q_o = shadow_q;
  assign in_isr_o   = in_isr_q;
endmodule

// File: rtl/lpm_gate_decode.sv
module lpm_gate_decode
  import lpm_pkg::*;
(
  input  logic [MODE_W-1:0] mode_i,
  input  logic              osc_in_use_i,
  output gate_t             gate_o
);
  always_comb begin
    gate_o = GATE_ALL_ON;
    case (mode_i)
      MODE_LPM0: gate_o = '{cpu:1'b0, mclk:1'b0, smclk:1'b1, aclk:1'b1, bias:1'b1, xtal:1'b1};
      MODE_LPM1: gate_o = '{cpu:1'b0, mclk:1'b0, smclk:1'b1, aclk:1'b1, bias:osc_in_use_i, xtal:1'b1};
      MODE_LPM2: gate_o = '{cpu:1'b0, mclk:1'b0, smclk:1'b0, aclk:1'b1, bias:1'b1, xtal:1'b1};
      MODE_LPM3: gate_o = '{cpu:1'b0, mclk:1'b0, smclk:1'b0, aclk:1'b1, bias:1'b0, xtal:1'b1};
      MODE_LPM4: gate_o = '0;
      default:   gate_o = GATE_ALL_ON; // active and unused codes
    endcase
  end
endmodule

// File: rtl/lpm_clk_ctrl.sv
module lpm_clk_ctrl
  import lpm_pkg::*;
#(
  parameter int unsigned NUM_IRQ = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               mode_we_i,
  input  logic [2:0]         mode_i,
  input  logic [NUM_IRQ-1:0] irq_i,
  input  logic               reti_i,
  input  logic               osc_in_use_i,
  output logic [2:0]         mode_o,
  output logic               cpu_en_o,
  output logic               mclk_en_o,
  output logic               smclk_en_o,
  output logic               aclk_en_o,
  output logic               bias_en_o,
  output logic               xtal_en_o
);
  logic              irq_any;
  logic              in_isr;
  logic [MODE_W-1:0] mode_d, mode_q, shadow_q;
  gate_t             gate_d, gate_q;

  assign irq_any = |irq_i;

  lpm_mode_seq u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .mode_we_i  (mode_we_i),
    .mode_i     (mode_i),
    .wake_req_i (irq_any),
    .reti_i     (reti_i),
    .mode_d_o   (mode_d),
    .mode_q_o   (mode_q),
    .shadow_q_o (shadow_q),
    .in_isr_o   (in_isr)
  );

  // decode the next mode so enables change on the same edge as the mode
  lpm_gate_decode u_dec (
    .mode_i       (mode_d),
    .osc_in_use_i (osc_in_use_i),
    .gate_o       (gate_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) gate_q <= GATE_ALL_ON;
    else         gate_q <= gate_d;
  end

  assign mode_o     = mode_q;
  assign cpu_en_o   = gate_q.cpu;
  assign mclk_en_o  = gate_q.mclk;
  assign smclk_en_o = gate_q.smclk;
  assign aclk_en_o  = gate_q.aclk;
  assign bias_en_o  = gate_q.bias;
  assign xtal_en_o  = gate_q.xtal;
endmodule

// File: rtl/lpm_clk_ctrl_chk.sv
module lpm_clk_ctrl_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       mode_we_i,
  input logic [2:0] mode_i,
  input logic       irq_any,
  input logic       reti_i,
  input logic       in_isr,
  input logic [2:0] shadow_q,
  input logic [2:0] mode_o,
  input logic       cpu_en_o,
  input logic       mclk_en_o,
  input logic       smclk_en_o,
  input logic       aclk_en_o,
  input logic       bias_en_o,
  input logic       xtal_en_o
);
  p_write_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_we_i && !(irq_any && !in_isr) && !(reti_i && in_isr)) |=> mode_o == $past(mode_i));

  p_cpu_am_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpu_en_o |-> (mode_o == 3'd0 || mode_o > 3'd5));

  p_gate_order_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !smclk_en_o |-> !mclk_en_o && !cpu_en_o);

  p_all_off_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o == 3'd5) |-> !(cpu_en_o || mclk_en_o || smclk_en_o || aclk_en_o || bias_en_o || xtal_en_o));

  p_xtal_last_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !xtal_en_o |-> !aclk_en_o);

  p_wake_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_any && !in_isr) |=> (mode_o == 3'd0 && in_isr && cpu_en_o && shadow_q == $past(mode_o)));

  p_restore_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reti_i && in_isr) |=> (mode_o == $past(shadow_q) && !in_isr));

  p_isr_hold_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_isr && !reti_i) |=> (in_isr && $stable(shadow_q)));
endmodule

bind lpm_clk_ctrl lpm_clk_ctrl_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .mode_we_i  (mode_we_i),
  .mode_i     (mode_i),
  .irq_any    (irq_any),
  .reti_i     (reti_i),
  .in_isr     (in_isr),
  .shadow_q   (shadow_q),
  .mode_o     (mode_o),
  .cpu_en_o   (cpu_en_o),
  .mclk_en_o  (mclk_en_o),
  .smclk_en_o (smclk_en_o),
  .aclk_en_o  (aclk_en_o),
  .bias_en_o  (bias_en_o),
  .xtal_en_o  (xtal_en_o)
);

// File: tb/lpm_clk_ctrl_test.sv
`timescale 1ns/1ps
module lpm_clk_ctrl_test;
  localparam int unsigned NUM_IRQ = 4;

  logic               clk = 1'b0;
  logic               rst_ni = 1'b0;
  logic               mode_we_i = 1'b0;
  logic [2:0]         mode_i = '0;
  logic [NUM_IRQ-1:0] irq_i = '0;
  logic               reti_i = 1'b0;
  logic               osc_in_use_i = 1'b1;
  logic [2:0]         mode_o;
  logic               cpu_en_o, mclk_en_o, smclk_en_o, aclk_en_o, bias_en_o, xtal_en_o;

  always #4 clk = ~clk; // 125 MHz

  lpm_clk_ctrl #(.NUM_IRQ(NUM_IRQ)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .mode_we_i(mode_we_i), .mode_i(mode_i),
    .irq_i(irq_i), .reti_i(reti_i), .osc_in_use_i(osc_in_use_i),
    .mode_o(mode_o), .cpu_en_o(cpu_en_o), .mclk_en_o(mclk_en_o),
    .smclk_en_o(smclk_en_o), .aclk_en_o(aclk_en_o), .bias_en_o(bias_en_o),
    .xtal_en_o(xtal_en_o)
  );

  typedef struct {
    logic [2:0] mode;
    logic [5:0] en;
    string      tag;
  } item_t;

  item_t q[$];
  int    n_vec = 0;
  int    n_bad = 0;

  // bench reference state
  logic [2:0] m_mode = 3'd0;
  logic [2:0] m_shadow = 3'd0;
  logic       m_isr = 1'b0;

  // {cpu,mclk,smclk,aclk,bias,xtal}
  function automatic logic [5:0] exp_gate(input logic [2:0] m, input logic osc);
    case (m)
      3'd1:    return 6'b001111;
      3'd2:    return {4'b0011, osc, 1'b1};
      3'd3:    return 6'b000111;
      3'd4:    return 6'b000101;
      3'd5:    return 6'b000000;
      default: return 6'b111111;
    endcase
  endfunction

  function automatic logic [5:0] dut_gate();
    return {cpu_en_o, mclk_en_o, smclk_en_o, aclk_en_o, bias_en_o, xtal_en_o};
  endfunction

  task automatic step(input logic we, input logic [2:0] m, input logic [NUM_IRQ-1:0] irq,
                      input logic reti, input logic osc, input string tag);
    item_t it;
    @(negedge clk);
    mode_we_i = we; mode_i = m; irq_i = irq; reti_i = reti; osc_in_use_i = osc;
    if ((|irq) && !m_isr) begin
      m_shadow = m_mode; m_mode = 3'd0; m_isr = 1'b1;
    end else if (reti && m_isr) begin
      m_mode = m_shadow; m_isr = 1'b0;
    end else if (we) begin
      m_mode = m;
    end
    it.mode = m_mode;
    it.en   = exp_gate(m_mode, osc);
    it.tag  = tag;
    q.push_back(it);
    @(posedge clk);
  endtask

  // monitor
  always @(posedge clk) begin
    #1;
    if (q.size() > 0) begin
      item_t it;
      it = q.pop_front();
      n_vec++;
      if (mode_o !== it.mode || dut_gate() !== it.en) begin
        n_bad++;
        $display("FAIL %s: mode=%0d en=%b expected mode=%0d en=%b",
                 it.tag, mode_o, dut_gate(), it.mode, it.en);
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    #13;
    n_vec++;
    if (mode_o !== 3'd0 || dut_gate() !== 6'b111111) begin
      n_bad++;
      $display("FAIL R1: mode=%0d en=%b expected mode=0 en=111111", mode_o, dut_gate());
    end
    @(negedge clk); rst_ni = 1'b1;
    step(0, 0, 0, 0, 1, "R1 idle after reset");
    step(1, 1, 0, 0, 1, "R3 LPM0");
    step(1, 2, 0, 0, 1, "R4 LPM1 osc used");
    step(0, 0, 0, 0, 0, "R4 LPM1 osc unused");
    step(1, 3, 0, 0, 1, "R5 LPM2");
    step(1, 4, 0, 0, 1, "R6 LPM3");
    step(1, 5, 0, 0, 1, "R7 LPM4");
    step(1, 0, 0, 0, 1, "R2 active");
    step(1, 6, 0, 0, 0, "R8 code 6");
    step(1, 7, 0, 0, 1, "R8 code 7");
    // wake from LPM3 and return
    step(1, 4, 0, 0, 1, "R6 enter LPM3");
    step(0, 0, 4'b0100, 0, 1, "R9 wake from LPM3");
    step(0, 0, 0, 0, 1, "R9 handler active");
    step(0, 0, 0, 1, 1, "R10 restore LPM3");
    step(0, 0, 0, 1, 1, "R11 reti outside handler");
    // wake from LPM4, nested irq ignored
    step(1, 5, 0, 0, 1, "R7 enter LPM4");
    step(1, 2, 4'b1001, 0, 1, "R9 wake wins over write");
    step(0, 0, 4'b0010, 0, 1, "R11 irq inside handler");
    step(0, 0, 4'b0001, 1, 1, "R10 restore LPM4 with irq held");
    // write inside handler
    step(1, 3, 0, 0, 1, "R5 enter LPM2");
    step(0, 0, 4'b1000, 0, 1, "R9 wake from LPM2");
    step(1, 1, 0, 0, 1, "R12 write in handler");
    step(0, 0, 0, 1, 1, "R12 restore LPM2");
    // interrupt in active mode returns to active
    step(1, 0, 0, 0, 1, "R2 active");
    step(0, 0, 4'b0001, 0, 1, "R9 irq in active mode");
    step(0, 0, 0, 1, 1, "R10 restore active");
    // LPM1 wake with osc unused
    step(1, 2, 0, 0, 0, "R4 LPM1 bias off");
    step(0, 0, 4'b0001, 0, 0, "R9 wake from LPM1");
    step(0, 0, 0, 1, 0, "R10 restore LPM1");
    step(0, 0, 0, 0, 1, "R4 LPM1 osc used again");
    repeat (3) @(posedge clk);
    #2;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule